// File: doc/BRIEF.md
# Dual-Address-Cycle Burst Read Master

This block is the bus-master side of a bridge between a simple local request port and a conventional 32-bit PCI bus. It performs burst reads whose 64-bit target address needs two address phases. A local agent holds its request strobe low and presents the low and high halves of the address, the dual-address command, the real read command and a word count. The block then arbitrates for the bus. When it wins, it latches the request and drives the low address with the dual-address command, then the high address with the read command. It then runs one data phase per word and hands each word back on the local side with a one-cycle strobe.

Parity for the address phases is driven one clock behind each phase. The parity the target returns with each data word is checked, and any mismatch is kept in a sticky flag. If no target claims the cycle within a set window, the block ends with a master-abort code. Otherwise it ends with a normal-completion code once the last word has moved. A 4-bit status code on the local side tracks each stage of the sequence.

Top module: `dac_rd_master`

## Requirements
- R1: While reset is applied and after it is released, `req_n`, `frame_n`, `irdy_n`, `lgnt_n` and `lxfer_n` are 1, `ad_oe`, `cbe_oe`, `par_oe` and `lpar_err` are 0, and `lstat` and `lterm` are 0. Applying reset in the middle of a transaction returns these values at once.
- R2: With `lstat` = 0 (idle), a low `lreq_n` makes `req_n` go low in the next cycle, and `lstat` becomes 1 (requesting).
- R3: The request is accepted at a clock edge where `lreq_n`, `gnt_n` are low and `bus_frame_n`, `bus_irdy_n` are both high. In the next cycle `lstat` is 2 (address loading) and `lgnt_n` is low for that one cycle. Both address halves, both commands and the length are latched at that edge. While the grant is missing or the bus is busy the block stays at `lstat` = 1, and if `lreq_n` returns high first, it goes back to idle.
- R4: In the cycle after address loading, `frame_n` is 0, `ad_oe` is 1, `ad_o` carries the latched low address and `cbe_n` carries the latched dual-address command.
- R5: In the next cycle `ad_o` carries the latched high address and `cbe_n` the latched read command, with `frame_n` still 0.
- R6: `par_oe` is 1 in exactly the cycle after each address phase. In that cycle `par_o` is the XOR of all 36 bits of `ad_o` and `cbe_n` from the cycle before, so that the XOR over the whole phase is even.
- R7: In data phases `irdy_n` is 0 and `cbe_n` is 0000. A word moves in each cycle where `trdy_n` is also 0. `frame_n` is 1 in the cycle in which the final word (word number `lreq_len`, length at least 1) can move. After the final word `irdy_n` and `frame_n` are 1 and `lterm` becomes 1 (normal completion).
- R8: `lbeats` (13 bits) is cleared at acceptance and rises by one for every word moved.
- R9: If `devsel_n` is not low in any of the first DEVSEL_WIN data-phase cycles, the transaction ends with `lterm` = 2 (master abort) and no word moved.
- R10: In the cycle after each word moves, `lxfer_n` is 0 for that one cycle and `lrdata` holds the word taken from `ad_i`.
- R11: `lpar_err` becomes 1 when `par_i` in the cycle after a moved word differs from the XOR of that word and the `cbe_n` driven with it. It stays 1 until the next acceptance clears it.
- R12: After termination `lstat` is 5 for one cycle and then returns to 0. `lterm` holds its code until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lreq_n | input | 1 | Local read request, active low |
| lreq_addr_lo | input | 32 | Low half of the start address |
| lreq_addr_hi | input | 32 | High half of the start address |
| lreq_cmd | input | 4 | Dual-address bus command for phase one |
| lreq_rd_cmd | input | 4 | Read bus command for phase two |
| lreq_len | input | 12 | Number of words to read |
| lgnt_n | output | 1 | Local grant pulse, active low |
| lstat | output | 4 | Sequence status code |
| lterm | output | 3 | Termination code |
| lbeats | output | 13 | Words moved in this transaction |
| lrdata | output | 32 | Read word |
| lxfer_n | output | 1 | Read word valid strobe, active low |
| lpar_err | output | 1 | Sticky read parity error |
| req_n | output | 1 | Bus request |
| gnt_n | input | 1 | Bus grant |
| bus_frame_n | input | 1 | FRAME# as seen on the bus |
| bus_irdy_n | input | 1 | IRDY# as seen on the bus |
| frame_n | output | 1 | FRAME# drive value |
| irdy_n | output | 1 | IRDY# drive value |
| ctl_oe | output | 1 | Drive enable for FRAME# and IRDY# |
| ad_o | output | 32 | AD drive value |
| ad_oe | output | 1 | AD drive enable |
| ad_i | input | 32 | AD as seen on the bus |
| cbe_n | output | 4 | C/BE# drive value |
| cbe_oe | output | 1 | C/BE# drive enable |
| par_o | output | 1 | PAR drive value |
| par_oe | output | 1 | PAR drive enable |
| par_i | input | 1 | PAR as seen on the bus |
| devsel_n | input | 1 | Target claim |
| trdy_n | input | 1 | Target ready |

## Verification
The bench builds the block with DEVSEL_WIN = 3 and the default 12-bit length. A 3-cycle claim window puts both sides of the abort boundary within short runs: a claim in the third data cycle completes, and one in the fourth aborts. The small window also keeps each abort run brief, so target wait states, a one-word burst that drops FRAME# at once, and a parity fault on the last word all fit in the same short table of transactions.

// File: rtl/dacrd_pkg.sv
package dacrd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_LOAD,
    S_ADR_LO,
    S_ADR_HI,
    S_DATA,
    S_TERM
  } seq_state_e;

  localparam logic [3:0] STAT_IDLE = 4'h0;
  localparam logic [3:0] STAT_WAIT = 4'h1;
  localparam logic [3:0] STAT_LOAD = 4'h2;
  localparam logic [3:0] STAT_ADDR = 4'h3;
  localparam logic [3:0] STAT_DATA = 4'h4;
  localparam logic [3:0] STAT_DONE = 4'h5;

  localparam logic [2:0] TERM_NONE   = 3'd0;
  localparam logic [2:0] TERM_NORMAL = 3'd1;
  localparam logic [2:0] TERM_MABORT = 3'd2;

endpackage

// File: rtl/dacrd_par_unit.sv
// Address parity generation and read-data parity checking.
module dacrd_par_unit #(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ad_drv_i,
  input  logic [CW-1:0] cbe_drv_i,
  input  logic          addr_ph_i,
  input  logic [DW-1:0] ad_in_i,
  input  logic          xfer_i,
  input  logic          par_in_i,
  input  logic          clr_err_i,
  output logic          par_o,
  output logic          par_oe_o,
  output logic          err_o
);

  logic par_q, oe_q, pend_q, exp_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q  <= 1'b0;
      oe_q   <= 1'b0;
      pend_q <= 1'b0;
      exp_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      par_q  <= ^{ad_drv_i, cbe_drv_i};
      oe_q   <= addr_ph_i;
      pend_q <= xfer_i;
      exp_q  <= ^{ad_in_i, cbe_drv_i};
      if (clr_err_i) begin
        err_q <= 1'b0;
      end else if (pend_q && (par_in_i != exp_q)) begin
        err_q <= 1'b1;
      end
    end
  end

  assign par_o    = par_q;
  assign par_oe_o = oe_q;
  assign err_o    = err_q;

endmodule

// File: rtl/dacrd_beat_ctr.sv
// Data-phase counter with final-word detection.
module dacrd_beat_ctr #(
  parameter int LEN_W = 12,
  parameter int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = ((cnt_q + CNT_W'(1)) == CNT_W'(len_i));

endmodule

// File: rtl/dacrd_dsel_tmr.sv
// Watches for a target claim within a fixed window of data cycles.
module dacrd_dsel_tmr #(
  parameter int WIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic active_i,
  input  logic devsel_n_i,
  output logic expired_o
);

  localparam int TW = $clog2(WIN + 1);

  logic [TW-1:0] cnt_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (active_i && !seen_q) begin
      cnt_q  <= cnt_q + TW'(1);
      seen_q <= ~devsel_n_i;
    end
  end

  assign expired_o = active_i && !seen_q && devsel_n_i && (cnt_q == TW'(WIN - 1));

endmodule

// File: rtl/dac_rd_master.sv
module dac_rd_master
  import dacrd_pkg::*;
#(
  parameter int DW         = 32,
  parameter int LEN_W      = 12,
  parameter int DEVSEL_WIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lreq_n,
  input  logic [DW-1:0]    lreq_addr_lo,
  input  logic [DW-1:0]    lreq_addr_hi,
  input  logic [DW/8-1:0]  lreq_cmd,
  input  logic [DW/8-1:0]  lreq_rd_cmd,
  input  logic [LEN_W-1:0] lreq_len,
  output logic             lgnt_n,
  output logic [3:0]       lstat,
  output logic [2:0]       lterm,
  output logic [LEN_W:0]   lbeats,
  output logic [DW-1:0]    lrdata,
  output logic             lxfer_n,
  output logic             lpar_err,
  output logic             req_n,
  input  logic             gnt_n,
  input  logic             bus_frame_n,
  input  logic             bus_irdy_n,
  output logic             frame_n,
  output logic             irdy_n,
  output logic             ctl_oe,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_i,
  output logic [DW/8-1:0]  cbe_n,
  output logic             cbe_oe,
  output logic             par_o,
  output logic             par_oe,
  input  logic             par_i,
  input  logic             devsel_n,
  input  logic             trdy_n
);

  localparam int CW    = DW / 8;
  localparam int CNT_W = LEN_W + 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  seq_state_e       state_q, state_d;
  logic [DW-1:0]    addr_lo_q, addr_hi_q, rdata_q;
  logic [CW-1:0]    cmd_q, rdcmd_q;
  logic [LEN_W-1:0] len_q;
  logic [2:0]       term_q;
  logic             xfer_n_q;
  logic             accept, xfer, last, dsel_exp, addr_ph;

  assign accept  = (state_q == S_REQ) && !lreq_n && !gnt_n && bus_frame_n && bus_irdy_n;
  assign xfer    = (state_q == S_DATA) && !trdy_n;
  assign addr_ph = (state_q == S_ADR_LO) || (state_q == S_ADR_HI);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:   if (!lreq_n) state_d = S_REQ;
      S_REQ:    if (lreq_n) state_d = S_IDLE;
                else if (accept) state_d = S_LOAD;
      S_LOAD:   state_d = S_ADR_LO;
      S_ADR_LO: state_d = S_ADR_HI;
      S_ADR_HI: state_d = S_DATA;
      S_DATA:   if ((xfer && last) || dsel_exp) state_d = S_TERM;
      S_TERM:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= S_IDLE;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      cmd_q     <= '0;
      rdcmd_q   <= '0;
      len_q     <= '0;
    end else if (accept) begin
      addr_lo_q <= lreq_addr_lo;
      addr_hi_q <= lreq_addr_hi;
      cmd_q     <= lreq_cmd;
      rdcmd_q   <= lreq_rd_cmd;
      len_q     <= lreq_len;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      term_q <= TERM_NONE;
    end else if (accept) begin
      term_q <= TERM_NONE;
    end else if (xfer && last) begin
      term_q <= TERM_NORMAL;
    end else if ((state_q == S_DATA) && dsel_exp) begin
      term_q <= TERM_MABORT;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata_q  <= '0;
      xfer_n_q <= 1'b1;
    end else begin
      xfer_n_q <= ~xfer;
      if (xfer) rdata_q <= ad_i;
    end
  end

  always_comb begin
    req_n   = 1'b1;
    lgnt_n  = 1'b1;
    frame_n = 1'b1;
    irdy_n  = 1'b1;
    ctl_oe  = 1'b0;
    ad_o    = '0;
    ad_oe   = 1'b0;
    cbe_n   = '0;
    cbe_oe  = 1'b0;
    lstat   = STAT_IDLE;
    case (state_q)
      S_REQ: begin
        req_n = 1'b0;
        lstat = STAT_WAIT;
      end
      S_LOAD: begin
        req_n  = 1'b0;
        lgnt_n = 1'b0;
        lstat  = STAT_LOAD;
      end
      S_ADR_LO: begin
        frame_n = 1'b0;
        ctl_oe  = 1'b1;
        ad_o    = addr_lo_q;
        ad_oe   = 1'b1;
        cbe_n   = cmd_q;
        cbe_oe  = 1'b1;
        lstat   = STAT_ADDR;
      end
      S_ADR_HI: begin
        frame_n = 1'b0;
        ctl_oe  = 1'b1;
        ad_o    = addr_hi_q;
        ad_oe   = 1'b1;
        cbe_n   = rdcmd_q;
        cbe_oe  = 1'b1;
        lstat   = STAT_ADDR;
      end
      S_DATA: begin
        frame_n = last;
        irdy_n  = 1'b0;
        ctl_oe  = 1'b1;
        cbe_oe  = 1'b1;
        lstat   = STAT_DATA;
      end
      S_TERM: begin
        ctl_oe = 1'b1;
        lstat  = STAT_DONE;
      end
      default: ;
    endcase
  end

  dacrd_par_unit #(.DW(DW), .CW(CW)) u_par (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ad_drv_i  (ad_o),
    .cbe_drv_i (cbe_n),
    .addr_ph_i (addr_ph),
    .ad_in_i   (ad_i),
    .xfer_i    (xfer),
    .par_in_i  (par_i),
    .clr_err_i (accept),
    .par_o     (par_o),
    .par_oe_o  (par_oe),
    .err_o     (lpar_err)
  );

  dacrd_beat_ctr #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (accept),
    .inc_i  (xfer),
    .len_i  (len_q),
    .cnt_o  (lbeats),
    .last_o (last)
  );

  dacrd_dsel_tmr #(.WIN(DEVSEL_WIN)) u_dsel (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (state_q == S_ADR_HI),
    .active_i   (state_q == S_DATA),
    .devsel_n_i (devsel_n),
    .expired_o  (dsel_exp)
  );

  assign lterm   = term_q;
  assign lrdata  = rdata_q;
  assign lxfer_n = xfer_n_q;

  AST_ACCEPT_LOAD: assert property (@(posedge clk) disable iff (!rst_int_n)
    accept |=> (lstat == STAT_LOAD && !lgnt_n && lbeats == '0)); // R3
  AST_ADDR_LO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!lgnt_n) |=> (!frame_n && ad_oe && ad_o == addr_lo_q && cbe_n == cmd_q)); // R4
  AST_ADDR_HI: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == S_ADR_LO) |=> (!frame_n && ad_o == addr_hi_q && cbe_n == rdcmd_q)); // R5
  AST_PAR_LAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    ad_oe |=> (par_oe && par_o == ^{$past(ad_o), $past(cbe_n)})); // R6
  AST_IRDY_RELEASE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!irdy_n && !trdy_n && frame_n) |=> (irdy_n && frame_n && lterm == TERM_NORMAL)); // R7
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!irdy_n && !trdy_n) |=> (lbeats == $past(lbeats) + CNT_W'(1))); // R8
  AST_MABORT: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((state_q == S_DATA) && dsel_exp) |=> (lterm == TERM_MABORT && irdy_n)); // R9
  AST_XFER_STROBE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!irdy_n && !trdy_n) |=> (!lxfer_n && lrdata == $past(ad_i))); // R10
  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lpar_err && !accept) |=> lpar_err); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lstat == STAT_DONE) |=> (lstat == STAT_IDLE)); // R12

endmodule

// File: tb/dac_rd_master_bench.sv
module dac_rd_master_bench;

  localparam int WIN = 3;
  localparam logic [3:0] DAC_CMD = 4'hD;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lreq_n;
  logic [31:0] lreq_addr_lo, lreq_addr_hi;
  logic [3:0]  lreq_cmd, lreq_rd_cmd;
  logic [11:0] lreq_len;
  logic        lgnt_n;
  logic [3:0]  lstat;
  logic [2:0]  lterm;
  logic [12:0] lbeats;
  logic [31:0] lrdata;
  logic        lxfer_n, lpar_err, req_n, gnt_n, bus_frame_n, bus_irdy_n;
  logic        frame_n, irdy_n, ctl_oe, ad_oe, cbe_oe, par_o, par_oe, par_i;
  logic [31:0] ad_o, ad_i;
  logic [3:0]  cbe_n;
  logic        devsel_n, trdy_n;
  logic        other_busy, gnt_hold;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  assign gnt_n       = req_n | gnt_hold;
  assign bus_frame_n = other_busy ? 1'b0 : (ctl_oe ? frame_n : 1'b1);
  assign bus_irdy_n  = ctl_oe ? irdy_n : 1'b1;

  dac_rd_master #(.DW(32), .LEN_W(12), .DEVSEL_WIN(WIN)) u_dac_rd_master (
    .clk(clk), .rst_n(rst_n), .lreq_n(lreq_n), .lreq_addr_lo(lreq_addr_lo),
    .lreq_addr_hi(lreq_addr_hi), .lreq_cmd(lreq_cmd), .lreq_rd_cmd(lreq_rd_cmd),
    .lreq_len(lreq_len), .lgnt_n(lgnt_n), .lstat(lstat), .lterm(lterm),
    .lbeats(lbeats), .lrdata(lrdata), .lxfer_n(lxfer_n), .lpar_err(lpar_err),
    .req_n(req_n), .gnt_n(gnt_n), .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .ctl_oe(ctl_oe), .ad_o(ad_o), .ad_oe(ad_oe),
    .ad_i(ad_i), .cbe_n(cbe_n), .cbe_oe(cbe_oe), .par_o(par_o), .par_oe(par_oe),
    .par_i(par_i), .devsel_n(devsel_n), .trdy_n(trdy_n)
  );

  // Transaction table: stimulus and expected results.
  localparam int NV = 6;
  localparam logic [11:0] T_LEN  [NV] = '{12'd3, 12'd1, 12'd5, 12'd2, 12'd4, 12'd6};
  localparam int          T_DLY  [NV] = '{1, 2, 3, 4, 0, 1};   // 0: never claimed
  localparam int          T_BAD  [NV] = '{0, 0, 2, 0, 0, 6};   // word with bad parity
  localparam bit          T_WS   [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [3:0]  T_RC   [NV] = '{4'h6, 4'hC, 4'hE, 4'h6, 4'hC, 4'h6};
  localparam logic [31:0] T_LO   [NV] = '{32'h1000_0040, 32'h8000_0000, 32'hFFFF_FFFC,
                                          32'h0000_0100, 32'h5A5A_0010, 32'h0123_4560};
  localparam logic [31:0] T_HI   [NV] = '{32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0080,
                                          32'h1234_5678, 32'h0000_0002, 32'hC000_0003};
  localparam logic [2:0]  T_TERM [NV] = '{3'd1, 3'd1, 3'd1, 3'd2, 3'd2, 3'd1};
  localparam int          T_NB   [NV] = '{3, 1, 5, 0, 0, 6};

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lreq_n = 1'b1; lreq_addr_lo = '0; lreq_addr_hi = '0; lreq_cmd = '0;
    lreq_rd_cmd = '0; lreq_len = '0; devsel_n = 1'b1; trdy_n = 1'b1;
    ad_i = '0; par_i = 1'b0;
  endtask

  task automatic run_vec(input int v);
    logic [31:0] base;
    logic [31:0] pend_ad;
    bit          pend;
    bit          tog;
    int          pend_no, sent, got, k;
    base = 32'hA500_0000 + (v << 8);
    pend = 0; tog = 0; pend_no = 0; sent = 0; got = 0; k = 1; pend_ad = '0;
    lreq_n = 1'b0; lreq_addr_lo = T_LO[v]; lreq_addr_hi = T_HI[v];
    lreq_cmd = DAC_CMD; lreq_rd_cmd = T_RC[v]; lreq_len = T_LEN[v];
    @(negedge clk);
    chk(req_n == 1'b0 && lstat == 4'h1, "R2", {27'd0, req_n, lstat}, 32'h1);
    @(negedge clk);
    chk(lstat == 4'h2 && lgnt_n == 1'b0, "R3", {27'd0, lgnt_n, lstat}, 32'h2);
    chk(lbeats == 13'd0, "R8", {19'd0, lbeats}, 32'd0);
    // Scramble inputs: the latched copies must be used from here on.
    lreq_n = 1'b1; lreq_addr_lo = ~T_LO[v]; lreq_addr_hi = ~T_HI[v];
    lreq_cmd = 4'h0; lreq_rd_cmd = 4'h0; lreq_len = 12'd0;
    @(negedge clk);
    chk(frame_n == 1'b0 && ad_oe && ad_o == T_LO[v], "R4", ad_o, T_LO[v]);
    chk(cbe_n == DAC_CMD, "R4", {28'd0, cbe_n}, {28'd0, DAC_CMD});
    @(negedge clk);
    chk(frame_n == 1'b0 && ad_o == T_HI[v] && cbe_n == T_RC[v], "R5", ad_o, T_HI[v]);
    chk(par_oe && par_o == ^{T_LO[v], DAC_CMD}, "R6", {31'd0, par_o}, {31'd0, ^{T_LO[v], DAC_CMD}});
    @(negedge clk);
    chk(par_oe && par_o == ^{T_HI[v], T_RC[v]}, "R6", {31'd0, par_o}, {31'd0, ^{T_HI[v], T_RC[v]}});
    for (int g = 0; g < 64; g++) begin
      if (!lxfer_n) begin
        chk(lrdata == base + got, "R10", lrdata, base + got);
        got++;
      end
      par_i = pend ? (^pend_ad ^ (pend_no == T_BAD[v])) : 1'b0;
      pend = 0;
      if (lstat != 4'h4) break;
      chk(irdy_n == 1'b0 && cbe_n == 4'h0, "R7", {27'd0, irdy_n, cbe_n}, 32'h0);
      chk(frame_n == (sent == int'(T_LEN[v]) - 1), "R7", {31'd0, frame_n},
          {31'd0, (sent == int'(T_LEN[v]) - 1)});
      devsel_n = !(T_DLY[v] != 0 && k >= T_DLY[v]);
      if (!devsel_n && (!T_WS[v] || tog)) begin
        trdy_n = 1'b0;
        ad_i = base + sent;
        sent++;
        pend = 1; pend_ad = ad_i; pend_no = sent;
      end else begin
        trdy_n = 1'b1;
        ad_i = 32'hDEAD_BEEF;
      end
      if (!devsel_n) tog = ~tog;
      k++;
      @(negedge clk);
    end
    devsel_n = 1'b1; trdy_n = 1'b1;
    chk(lstat == 4'h5 && irdy_n && frame_n, "R7", {26'd0, irdy_n, frame_n, lstat}, 32'h35);
    @(negedge clk);
    chk(lstat == 4'h0, "R12", {28'd0, lstat}, 32'h0);
    chk(lterm == T_TERM[v], (T_TERM[v] == 3'd2) ? "R9" : "R7", {29'd0, lterm}, {29'd0, T_TERM[v]});
    chk(lbeats == 13'(T_NB[v]), "R8", {19'd0, lbeats}, T_NB[v]);
    chk(got == T_NB[v], "R10", got, T_NB[v]);
    chk(lpar_err == (T_BAD[v] != 0), "R11", {31'd0, lpar_err}, {31'd0, (T_BAD[v] != 0)});
    par_i = 1'b0;
    @(negedge clk);
    chk(lterm == T_TERM[v] && lstat == 4'h0, "R12", {29'd0, lterm}, {29'd0, T_TERM[v]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; other_busy = 1'b0; gnt_hold = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    chk(req_n && frame_n && irdy_n && lgnt_n && !ad_oe && lstat == 4'h0, "R1",
        {26'd0, req_n, frame_n, irdy_n, lgnt_n, ad_oe, 1'b0}, 32'h3C);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(lxfer_n && !par_oe && !cbe_oe && !lpar_err && lterm == 3'd0, "R1",
        {28'd0, lxfer_n, par_oe, cbe_oe, lpar_err}, 32'h8);

    // Bus busy: request must wait, then withdraw.
    other_busy = 1'b1;
    lreq_n = 1'b0; lreq_addr_lo = 32'h1; lreq_cmd = DAC_CMD; lreq_len = 12'd1;
    repeat (4) @(negedge clk);
    chk(lstat == 4'h1 && lgnt_n && !req_n, "R3", {27'd0, lgnt_n, lstat}, 32'h11);
    lreq_n = 1'b1;
    @(negedge clk);
    chk(lstat == 4'h0 && req_n, "R3", {27'd0, req_n, lstat}, 32'h10);
    other_busy = 1'b0;

    // Grant withheld.
    gnt_hold = 1'b1;
    lreq_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(lstat == 4'h1 && lgnt_n, "R3", {27'd0, lgnt_n, lstat}, 32'h11);
    lreq_n = 1'b1;
    @(negedge clk);
    gnt_hold = 1'b0;
    idle_inputs();
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_vec(v);
    end

    // Reset in flight.
    lreq_n = 1'b0; lreq_addr_lo = 32'h44; lreq_cmd = DAC_CMD; lreq_len = 12'd2;
    repeat (3) @(negedge clk);
    chk(frame_n == 1'b0, "R4", {31'd0, frame_n}, 32'h0);
    rst_n = 1'b0;
    #1;
    chk(frame_n && !ad_oe && req_n && lstat == 4'h0 && lterm == 3'd0, "R1",
        {26'd0, frame_n, ad_oe, req_n, lstat[2:0]}, 32'h28);
    idle_inputs();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_vec(0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule